// File: doc/BRIEF.md
# Segmented Two-Register Test Pattern Generator

This block feeds a circuit under test with one fresh input pattern on every clock cycle. Its M output columns come from two small pattern registers. One is a conventional internal-feedback LFSR. The other is a sparse register that is either a plain ring counter or a ring with one extra feedback tap at its midpoint. A compile-time map decides, for each column, which register drives it and which bit of that register it takes. A compile-time mask inverts selected columns. Because of the mask, a column whose useful values are mostly 1 can still be driven by a register that is mostly 0. The only logic between the registers and the columns is inverters and XOR gates.

A small state machine controls the run. The generator leaves reset in `ST_IDLE` with both registers at their seed. The first cycle with the enable high moves it to `ST_RUN`, and every cycle with the enable high steps both registers together. When the enable drops during a run, it moves to `ST_PAUSE` and holds. When the enable returns, it goes back to `ST_RUN`. The step that reaches the configured test length moves it to `ST_DONE`. In `ST_DONE` the pattern is frozen and the done flag stays high until reset.

Top module: `segtpg_top`

## Requirements
- R1: While reset is active and on the first cycle after it, both registers hold their seed, with only stage 0 set. With the default map and mask the pattern output is then 8'h25, and done is low.
- R2: The conventional register has NC stages and follows x^NC+x+1 in internal form. On each step, stage 0 takes the old last stage, stage 1 takes old stage 0 XOR old last stage, and every other stage i takes old stage i-1. For NC=4 its sequence repeats every 15 steps.
- R3: The special register has NS stages. In mode 0 (ring, x^NS+1), stage 0 takes the old last stage and every other stage takes its predecessor. In mode 1 (x^NS+x^(NS/2)+1), stage NS/2 instead takes its predecessor XOR the old last stage. For NS=4 the repeat lengths are 4 in mode 0 and 6 in mode 1.
- R4: Output column c equals bit COL_BIT[c] of the special register when COL_SEL_SP[c] is 1, or of the conventional register when it is 0, XOR INV_MASK[c]. In the default map, even column 2k takes special bit k, odd column 2k+1 takes conventional bit k, and the mask is 8'h26.
- R5: A step happens on every rising edge where the enable is high and the state is not `ST_DONE`. Both registers advance on that same edge.
- R6: On an edge where the enable is low, neither register moves, so the pattern output keeps its value.
- R7: The step that brings the step count to TEST_LEN moves the state to `ST_DONE`. From the next cycle on, done is high, it stays high, and the pattern output no longer changes, whatever the enable does.
- R8: Reset applied in the middle of a run or after done returns both registers to their seed, clears the step count and clears done. A following run starts again from the beginning of its sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Step enable |
| pattern | output | M | Pattern applied to the circuit under test this cycle |
| done | output | 1 | High once TEST_LEN steps have been applied |

## Verification
The hardest condition to reach is the one where the enable changes on the very step that brings the count to the test length. If that cycle is handled wrongly, the generator either takes one step too many or stops one step early. The stimulus gates the enable with an irregular pattern that changes for several cycles on either side of the final step. After that, the enable keeps toggling well past done, so any extra step shows up in the frozen pattern. Each register's full repeat length is covered several times inside one run: the bench tracks both registers arithmetically and compares every cycle. A second instance in ring mode receives the same stimulus, so both variants of the special register are checked.

// File: rtl/segtpg_pkg.sv
package segtpg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_PAUSE = 2'd2,
        ST_DONE  = 2'd3
    } tpg_state_e;

    localparam int SP_RING    = 0;
    localparam int SP_HALFTAP = 1;
endpackage

// File: rtl/segtpg_conv_lfsr.sv
module segtpg_conv_lfsr #(
    parameter int NC = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    output logic [NC-1:0] q
);
    logic [NC-1:0] nxt;

    always_comb begin
        nxt    = {q[NC-2:0], q[NC-1]};
        nxt[1] = q[0] ^ q[NC-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= NC'(1);
        end else if (step) begin
            q <= nxt;
        end
    end
endmodule

// File: rtl/segtpg_sp_reg.sv
module segtpg_sp_reg #(
    parameter int NS   = 4,
    parameter int MODE = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    output logic [NS-1:0] q
);
    localparam int HALF = NS / 2;
    logic [NS-1:0] nxt;

    generate
        if (MODE == 1) begin : g_halftap
            always_comb begin
                nxt       = {q[NS-2:0], q[NS-1]};
                nxt[HALF] = q[HALF-1] ^ q[NS-1];
            end
        end else begin : g_ring
            always_comb begin
                nxt = {q[NS-2:0], q[NS-1]};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= NS'(1);
        end else if (step) begin
            q <= nxt;
        end
    end
endmodule

// File: rtl/segtpg_col_map.sv
module segtpg_col_map #(
    parameter int              M          = 8,
    parameter int              NS         = 4,
    parameter int              NC         = 4,
    parameter int              IW         = 4,
    parameter logic [M-1:0]    COL_SEL_SP = 8'h55,
    parameter logic [M*IW-1:0] COL_BIT    = 32'h3322_1100,
    parameter logic [M-1:0]    INV_MASK   = 8'h26
) (
    input  logic [NS-1:0] sp_q,
    input  logic [NC-1:0] conv_q,
    output logic [M-1:0]  cols
);
    for (genvar c = 0; c < M; c++) begin : g_col
        localparam int IDX = int'(COL_BIT[c*IW +: IW]);
        if (COL_SEL_SP[c]) begin : g_sp
            assign cols[c] = sp_q[IDX % NS] ^ INV_MASK[c];
        end else begin : g_conv
            assign cols[c] = conv_q[IDX % NC] ^ INV_MASK[c];
        end
    end
endmodule

// File: rtl/segtpg_ctrl.sv
module segtpg_ctrl
    import segtpg_pkg::*;
#(
    parameter int TEST_LEN = 40,
    localparam int CW      = $clog2(TEST_LEN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    output logic          step,
    output logic          done,
    output logic [CW-1:0] cnt,
    output tpg_state_e    state
);
    tpg_state_e nxt_state;
    logic       last_step;

    assign last_step = (cnt == CW'(TEST_LEN - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt_state;
            if (step) begin
                cnt <= cnt + CW'(1);
            end
        end
    end

    always_comb begin
        nxt_state = state;
        unique case (state)
            ST_IDLE: begin
                if (en) nxt_state = last_step ? ST_DONE : ST_RUN;
            end
            ST_RUN: begin
                if (en) nxt_state = last_step ? ST_DONE : ST_RUN;
                else    nxt_state = ST_PAUSE;
            end
            ST_PAUSE: begin
                if (en) nxt_state = last_step ? ST_DONE : ST_RUN;
            end
            ST_DONE: nxt_state = ST_DONE;
            default: nxt_state = ST_IDLE;
        endcase
    end

    always_comb begin
        step = 1'b0;
        done = 1'b0;
        unique case (state)
            ST_IDLE, ST_RUN, ST_PAUSE: step = en;
            ST_DONE:                   done = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/segtpg_top.sv
module segtpg_top
    import segtpg_pkg::*;
#(
    parameter int              M          = 8,
    parameter int              NS         = 4,
    parameter int              NC         = 4,
    parameter int              SP_MODE    = SP_HALFTAP,
    parameter int              IW         = 4,
    parameter logic [M-1:0]    COL_SEL_SP = 8'h55,
    parameter logic [M*IW-1:0] COL_BIT    = 32'h3322_1100,
    parameter logic [M-1:0]    INV_MASK   = 8'h26,
    parameter int              TEST_LEN   = 40
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    output logic [M-1:0] pattern,
    output logic         done
);
    localparam int CW = $clog2(TEST_LEN + 1);

    logic          step;
    logic [CW-1:0] cnt;
    tpg_state_e    state;
    logic [NS-1:0] sp_q;
    logic [NC-1:0] conv_q;

    segtpg_ctrl #(.TEST_LEN(TEST_LEN)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .step  (step),
        .done  (done),
        .cnt   (cnt),
        .state (state)
    );

    segtpg_sp_reg #(.NS(NS), .MODE(SP_MODE)) u_sp (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step),
        .q     (sp_q)
    );

    segtpg_conv_lfsr #(.NC(NC)) u_conv (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step),
        .q     (conv_q)
    );

    segtpg_col_map #(
        .M(M), .NS(NS), .NC(NC), .IW(IW),
        .COL_SEL_SP(COL_SEL_SP), .COL_BIT(COL_BIT), .INV_MASK(INV_MASK)
    ) u_map (
        .sp_q   (sp_q),
        .conv_q (conv_q),
        .cols   (pattern)
    );
endmodule

// File: rtl/segtpg_chk.sv
module segtpg_chk #(
    parameter int M        = 8,
    parameter int NS       = 4,
    parameter int NC       = 4,
    parameter int SP_MODE  = 1,
    parameter int TEST_LEN = 40,
    parameter int CW       = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic [M-1:0]  pattern,
    input logic          done,
    input logic [NS-1:0] sp_q,
    input logic [NC-1:0] conv_q,
    input logic [CW-1:0] cnt
);
    // R6: enable low holds both registers
    a_r6_hold_regs: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !done) |=> ($stable(sp_q) && $stable(conv_q)));

    // R7: done is sticky and freezes the output
    a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);
    a_r7_done_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> $stable(pattern));

    // R5: the step count never exceeds the test length
    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(TEST_LEN));

    // R7: done and a full count go together
    a_r7_done_at_len: assert property (@(posedge clk) disable iff (!rst_n)
        done == (cnt == CW'(TEST_LEN)));

    // R2: the conventional register never falls into the all-zero state
    a_r2_conv_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        conv_q != '0);

    // R3: the special register stays sparse
    generate
        if (SP_MODE == 0) begin : g_ring_chk
            a_r3_ring_onehot: assert property (@(posedge clk) disable iff (!rst_n)
                $countones(sp_q) == 1);
        end else begin : g_half_chk
            a_r3_half_sparse: assert property (@(posedge clk) disable iff (!rst_n)
                ($countones(sp_q) == 1) || ($countones(sp_q) == 2));
        end
    endgenerate
endmodule

bind segtpg_top segtpg_chk #(
    .M(M), .NS(NS), .NC(NC), .SP_MODE(SP_MODE), .TEST_LEN(TEST_LEN), .CW(CW)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .pattern (pattern),
    .done    (done),
    .sp_q    (sp_q),
    .conv_q  (conv_q),
    .cnt     (cnt)
);

// File: tb/segtpg_top_bench.sv
module segtpg_top_bench;
    localparam int TLEN = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [7:0] pat_h, pat_r;
    logic       done_h, done_r;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    // bench model state
    logic [3:0] m_sph, m_spr, m_cv;
    int         m_cnt;

    always #2.5 clk = ~clk;

    segtpg_top #(.SP_MODE(1), .TEST_LEN(TLEN)) u_segtpg_top (
        .clk(clk), .rst_n(rst_n), .en(en), .pattern(pat_h), .done(done_h));

    segtpg_top #(.SP_MODE(0), .TEST_LEN(TLEN)) u_segtpg_top_ring (
        .clk(clk), .rst_n(rst_n), .en(en), .pattern(pat_r), .done(done_r));

    function automatic logic [3:0] conv_nx(logic [3:0] q);
        return {q[2], q[1], q[0] ^ q[3], q[3]};
    endfunction

    function automatic logic [3:0] sp_nx(logic [3:0] q, bit half);
        logic [3:0] n;
        n = {q[2:0], q[3]};
        if (half) n[2] = q[1] ^ q[3];
        return n;
    endfunction

    // even col 2k <- sp[k], odd col 2k+1 <- conv[k], then XOR 8'h26
    function automatic logic [7:0] cols(logic [3:0] sp, logic [3:0] cv);
        logic [7:0] r;
        for (int k = 0; k < 4; k++) begin
            r[2*k]   = sp[k];
            r[2*k+1] = cv[k];
        end
        return r ^ 8'h26;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s at cycle %0d: actual %h expected %h", req, cyc, act, exp);
        end
    endtask

    task automatic model_reset();
        m_sph = 4'b0001; m_spr = 4'b0001; m_cv = 4'b0001; m_cnt = 0;
    endtask

    task automatic compare_all();
        logic [7:0] eh, er;
        logic       ed;
        eh = cols(m_sph, m_cv);
        er = cols(m_spr, m_cv);
        ed = (m_cnt == TLEN);
        chk("R2", pat_h & 8'hAA, eh & 8'hAA);
        chk("R3", pat_h & 8'h55, eh & 8'h55);
        chk("R3", pat_r, er);
        chk("R7", {7'd0, done_h}, {7'd0, ed});
        chk("R7", {7'd0, done_r}, {7'd0, ed});
    endtask

    // one cycle: sample at negedge, apply en, model the coming edge
    task automatic cycle(input logic e);
        @(negedge clk);
        compare_all();
        en = e;
        if (e && m_cnt < TLEN) begin
            m_sph = sp_nx(m_sph, 1'b1);
            m_spr = sp_nx(m_spr, 1'b0);
            m_cv  = conv_nx(m_cv);
            m_cnt++;
        end
    endtask

    initial begin : wdog
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        logic [7:0] held;
        model_reset();
        repeat (3) @(negedge clk);
        // R1 / R4: seed image during reset
        chk("R1", pat_h, 8'h25);
        chk("R4", pat_r, 8'h25);
        chk("R1", {7'd0, done_h}, 8'd0);
        @(negedge clk);
        rst_n = 1'b1;
        cycle(1'b0);
        cycle(1'b0);
        // R5 / R6: irregular enable, run to done and well beyond
        for (int i = 0; i < 90; i++) begin
            cycle(((i % 5) != 2) && ((i % 11) != 7));
        end
        // R7: enable toggled after done; pattern frozen
        @(negedge clk);
        held = pat_h;
        for (int i = 0; i < 10; i++) begin
            en = i[0];
            @(negedge clk);
            chk("R7", pat_h, held);
        end
        // R8: reset after done, then mid-run reset
        en = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        model_reset();
        chk("R8", pat_h, 8'h25);
        chk("R8", {7'd0, done_h}, 8'd0);
        rst_n = 1'b1;
        for (int i = 0; i < 13; i++) cycle(1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        en = 1'b0;
        model_reset();
        @(negedge clk);
        chk("R8", pat_r, 8'h25);
        rst_n = 1'b1;
        // R5: continuous enable, final step boundary
        for (int i = 0; i < 50; i++) cycle(1'b1);
        for (int i = 0; i < 6; i++) cycle(1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule